// File: doc/BRIEF.md
# Exception Context Sequencer

This block controls the memory traffic that happens around an exception handler. When the priority arbiter presents a pending exception and the core is in thread mode, the sequencer writes a frame of saved words to a descending stack. It then reads the handler's entry address from a vector table and raises a one-cycle branch strobe. When the handler returns, the sequencer reads the frame back and releases the stack space.

Three shortcuts change this basic sequence. A return that finds another exception already pending goes straight to that exception's vector read, with no unstack and no restack. A more urgent exception that appears while the frame is being written takes over the pending vector read. An exception that appears while the frame is being read back stops the unstack at the next completed beat. The saved frame stays in place in that case.

Every memory beat uses a request/ready handshake. The sequencer reports each change of the active exception to the arbiter through a strobe plus the number and priority.

Top module: `exc_seq`

## Requirements
- R1: After reset, `mem_req`, `branch`, `act_upd` and `act_valid` are low and `sp` equals `SP_INIT`.
- R2: On entry the block issues `FRAME_WORDS` writes. Write k (k = 0 upward) goes to address `sp - 4*(k+1)` with `mem_slot = k`. After the last write completes, `sp` drops by `4*FRAME_WORDS`.
- R3: After stacking, the block reads the single word at `VTAB_BASE + 4*act_num`. That word appears on `handler_addr` while `branch` is high for exactly one cycle.
- R4: A return strobe with no exception pending produces `FRAME_WORDS` reads. Read j goes to `sp + 4*j` with `mem_slot = FRAME_WORDS-1-j`. After the last read, `sp` rises by `4*FRAME_WORDS` and `act_valid` falls.
- R5: A return strobe while `pend_valid` is high (tail chain) issues no pop reads. The next memory access is the vector read of the pending exception, and `sp` stays unchanged.
- R6: While the frame is being written, a pending exception with a numerically smaller `pend_prio` becomes the active exception. A smaller value means more urgent. A pending exception with an equal or larger value is ignored. The writes continue, and the vector read uses the latest active number.
- R7: During unstacking, a beat that completes while `pend_valid` is high ends the unstack. The pending exception becomes active and its vector is read next. `sp` keeps the frame value, and a later return pops the full frame.
- R8: While `mem_req` is high and `mem_ready` is low, the address, slot, direction, `sp` and sequence position hold.
- R9: Each time a new exception becomes active (entry, R5, R6 or R7), `act_upd` is high for one cycle. In that cycle `act_num` and `act_prio` already show the new exception.
- R10: A return strobe outside a running handler has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_valid | input | 1 | Arbiter has a pending exception |
| pend_num | input | EXC_W | Number of highest pending exception |
| pend_prio | input | PRIO_W | Its priority (smaller is more urgent) |
| hret | input | 1 | Handler-return strobe |
| mem_ready | input | 1 | Memory accepts/completes the current beat |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write (push), 0 = read |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_slot | output | CNT_W | Frame slot being saved or restored |
| sp | output | ADDR_W | Stack pointer |
| handler_addr | output | DATA_W | Fetched handler address |
| branch | output | 1 | One-cycle strobe: branch to `handler_addr` |
| act_upd | output | 1 | Active exception changed |
| act_valid | output | 1 | An exception is active |
| act_num | output | EXC_W | Active exception number |
| act_prio | output | PRIO_W | Active exception priority |

## Verification
The bench builds the block with 16 exception numbers, 3 priority bits and an 8-word frame. It sets a non-zero table base and a stack start of 0x2000_1000, so every push, pop and vector address differs from its offset alone and from the reset value. With 3-bit priorities, the bench can place an ignored lower-urgency arrival and an accepted higher-urgency arrival within one stacking pass. The 8-word frame leaves enough beats to inject a redirect in the middle of a push or a pop. A bench-side ready gate holds the first push for several cycles to exercise the stall rule.

// File: rtl/exc_seq_pkg.sv
// Shared types for the exception context sequencer.
package exc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // thread mode, no exception active
        ST_PUSH  = 3'd1,  // writing the context frame
        ST_FETCH = 3'd2,  // reading the vector table
        ST_HDL   = 3'd3,  // handler running
        ST_POP   = 3'd4   // reading the context frame back
    } seq_state_e;
endpackage

// File: rtl/exc_seq_ctrl.sv
// Sequencer control: state machine and frame beat counter.
// Assumes mem_ready is only meaningful while mem_req is high, and that
// exceptions are taken from thread mode only (the arbiter masks nesting).
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int unsigned FRAME_WORDS = 8,
    parameter int unsigned PRIO_W      = 3,
    localparam int unsigned CNT_W      = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] act_prio,
    input  logic              hret,
    input  logic              mem_ready,
    output seq_state_e        state,
    output logic [CNT_W-1:0]  cnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic              load_act,
    output logic              sp_dec,
    output logic              sp_inc,
    output logic              hdl_load,
    output logic              clr_act
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state, beat counter and datapath strobes.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        load_act = 1'b0;
        sp_dec   = 1'b0;
        sp_inc   = 1'b0;
        hdl_load = 1'b0;
        clr_act  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_valid) begin
                    load_act = 1'b1;
                    cnt_d    = '0;
                    state_d  = ST_PUSH;
                end
            end
            ST_PUSH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (pend_valid && (pend_prio < act_prio)) load_act = 1'b1;
                if (mem_ready) begin
                    if (cnt_q == LAST) begin
                        sp_dec  = 1'b1;
                        cnt_d   = '0;
                        state_d = ST_FETCH;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    hdl_load = 1'b1;
                    state_d  = ST_HDL;
                end
            end
            ST_HDL: begin
                if (hret) begin
                    cnt_d = '0;
                    if (pend_valid) begin
                        load_act = 1'b1;
                        state_d  = ST_FETCH;
                    end else begin
                        state_d = ST_POP;
                    end
                end
            end
            ST_POP: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    if (pend_valid) begin
                        load_act = 1'b1;
                        cnt_d    = '0;
                        state_d  = ST_FETCH;
                    end else if (cnt_q == LAST) begin
                        sp_inc  = 1'b1;
                        clr_act = 1'b1;
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;
    assign cnt   = cnt_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> ($stable(state_q) && $stable(cnt_q))); // R8
endmodule

// File: rtl/exc_seq_dp.sv
// Sequencer datapath: stack pointer, active exception, beat address
// generation and handler address capture. Driven entirely by strobes
// from exc_seq_ctrl; the stack pointer moves only at frame boundaries.
module exc_seq_dp
    import exc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned EXC_W       = 4,
    parameter int unsigned PRIO_W      = 3,
    parameter int unsigned FRAME_WORDS = 8,
    parameter logic [ADDR_W-1:0] SP_INIT   = '0,
    parameter logic [ADDR_W-1:0] VTAB_BASE = '0,
    localparam int unsigned CNT_W      = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              load_act,
    input  logic              sp_dec,
    input  logic              sp_inc,
    input  logic              hdl_load,
    input  logic              clr_act,
    input  logic [EXC_W-1:0]  pend_num,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  mem_slot,
    output logic [ADDR_W-1:0] sp,
    output logic [DATA_W-1:0] handler_addr,
    output logic              branch,
    output logic              act_upd,
    output logic              act_valid,
    output logic [EXC_W-1:0]  act_num,
    output logic [PRIO_W-1:0] act_prio
);
    localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME_WORDS * 4);
    localparam logic [CNT_W-1:0]  LAST        = CNT_W'(FRAME_WORDS - 1);

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] word_off;

    assign word_off = ADDR_W'(cnt) << 2;

    // Beat address and frame slot for the current state.
    always_comb begin
        mem_addr = '0;
        mem_slot = '0;
        unique case (state)
            ST_PUSH: begin
                mem_addr = sp_q - word_off - ADDR_W'(4);
                mem_slot = cnt;
            end
            ST_FETCH: mem_addr = VTAB_BASE + (ADDR_W'(act_num) << 2);
            ST_POP: begin
                mem_addr = sp_q + word_off;
                mem_slot = LAST - cnt;
            end
            default: mem_addr = '0;
        endcase
    end

    // Stack pointer: moves by one frame when a push or pop frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= SP_INIT;
        else if (sp_dec) sp_q <= sp_q - FRAME_BYTES;
        else if (sp_inc) sp_q <= sp_q + FRAME_BYTES;
    end

    // Active exception record and its update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_num   <= '0;
            act_prio  <= '0;
            act_upd   <= 1'b0;
        end else begin
            act_upd <= load_act;
            if (load_act) begin
                act_valid <= 1'b1;
                act_num   <= pend_num;
                act_prio  <= pend_prio;
            end else if (clr_act) begin
                act_valid <= 1'b0;
            end
        end
    end

    // Handler address capture and branch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_addr <= '0;
            branch       <= 1'b0;
        end else begin
            branch <= hdl_load;
            if (hdl_load) handler_addr <= mem_rdata;
        end
    end

    assign sp = sp_q;

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_q) |-> ((sp_q == $past(sp_q) - FRAME_BYTES) || (sp_q == $past(sp_q) + FRAME_BYTES))); // R2
    AST_BRANCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        branch |=> !branch); // R3
    AST_LATE_MORE_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && state == ST_PUSH) |=> (act_prio < $past(act_prio))); // R6
    AST_POP_ABORT_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && state == ST_POP) |=> $stable(sp_q)); // R7
    AST_BRANCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        branch |-> act_valid); // R9
endmodule

// File: rtl/exc_seq.sv
// Exception context sequencer top: pushes a context frame on exception
// entry, fetches the handler vector, pops on return, and applies tail
// chaining, late arrival and pop preemption. Assumes a single-beat,
// ready-handshaked memory port and an external priority arbiter.
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_EXC     = 16,
    parameter int unsigned PRIO_W      = 3,
    parameter int unsigned FRAME_WORDS = 8,
    parameter logic [ADDR_W-1:0] SP_INIT   = 32'h2000_1000,
    parameter logic [ADDR_W-1:0] VTAB_BASE = '0,
    localparam int unsigned EXC_W      = $clog2(NUM_EXC),
    localparam int unsigned CNT_W      = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic [EXC_W-1:0]  pend_num,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              hret,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  mem_slot,
    output logic [ADDR_W-1:0] sp,
    output logic [DATA_W-1:0] handler_addr,
    output logic              branch,
    output logic              act_upd,
    output logic              act_valid,
    output logic [EXC_W-1:0]  act_num,
    output logic [PRIO_W-1:0] act_prio
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             load_act, sp_dec, sp_inc, hdl_load, clr_act;

    exc_seq_ctrl #(
        .FRAME_WORDS(FRAME_WORDS),
        .PRIO_W     (PRIO_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_valid(pend_valid),
        .pend_prio (pend_prio),
        .act_prio  (act_prio),
        .hret      (hret),
        .mem_ready (mem_ready),
        .state     (state),
        .cnt       (cnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .load_act  (load_act),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc),
        .hdl_load  (hdl_load),
        .clr_act   (clr_act)
    );

    exc_seq_dp #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .EXC_W      (EXC_W),
        .PRIO_W     (PRIO_W),
        .FRAME_WORDS(FRAME_WORDS),
        .SP_INIT    (SP_INIT),
        .VTAB_BASE  (VTAB_BASE)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .cnt         (cnt),
        .load_act    (load_act),
        .sp_dec      (sp_dec),
        .sp_inc      (sp_inc),
        .hdl_load    (hdl_load),
        .clr_act     (clr_act),
        .pend_num    (pend_num),
        .pend_prio   (pend_prio),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_slot    (mem_slot),
        .sp          (sp),
        .handler_addr(handler_addr),
        .branch      (branch),
        .act_upd     (act_upd),
        .act_valid   (act_valid),
        .act_num     (act_num),
        .act_prio    (act_prio)
    );
endmodule

// File: tb/test_exc_seq.sv
// Directed bench for exc_seq: one task per scenario, each checking itself.
module test_exc_seq;
    localparam int unsigned    FW    = 8;
    localparam logic [31:0]    SPI   = 32'h2000_1000;
    localparam logic [31:0]    VTB   = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pend_valid;
    logic [3:0]  pend_num;
    logic [2:0]  pend_prio;
    logic        hret;
    logic        rdy_en;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, sp, handler_addr;
    logic [2:0]  mem_slot;
    logic        branch, act_upd, act_valid;
    logic [3:0]  act_num;
    logic [2:0]  act_prio;

    always #10 clk = ~clk;

    assign mem_ready = mem_req & rdy_en;
    assign mem_rdata = 32'hC0DE_0000 ^ mem_addr;

    exc_seq #(
        .NUM_EXC(16), .PRIO_W(3), .FRAME_WORDS(FW),
        .SP_INIT(SPI), .VTAB_BASE(VTB)
    ) i_exc_seq (
        .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_num(pend_num),
        .pend_prio(pend_prio), .hret(hret), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_slot(mem_slot),
        .sp(sp), .handler_addr(handler_addr), .branch(branch), .act_upd(act_upd),
        .act_valid(act_valid), .act_num(act_num), .act_prio(act_prio)
    );

    // Transfer log: one entry per completed memory beat.
    logic [31:0] lg_addr [0:63];
    logic        lg_we   [0:63];
    logic [2:0]  lg_slot [0:63];
    int          lg_n;
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready && lg_n < 64) begin
            lg_addr[lg_n] = mem_addr;
            lg_we[lg_n]   = mem_we;
            lg_slot[lg_n] = mem_slot;
            lg_n          = lg_n + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_log(input int n);
        do @(posedge clk); while (lg_n < n);
        #2;
    endtask

    task automatic wait_branch(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (branch) begin seen = 1'b1; break; end
        end
    endtask

    // Raise an exception, check the report strobe, the pushes and the fetch.
    task automatic do_entry(input logic [3:0] num, input logic [2:0] prio);
        bit seen;
        int bad;
        lg_n = 0;
        pend_valid = 1'b1; pend_num = num; pend_prio = prio;
        tick();
        pend_valid = 1'b0;
        @(negedge clk);
        chk("R9", "act_upd on entry", 32'(act_upd), 32'd1);
        chk("R9", "act_num on entry", 32'(act_num), 32'(num));
        wait_branch(seen);
        chk("R3", "branch seen", 32'(seen), 32'd1);
        chk("R3", "handler_addr", handler_addr, 32'hC0DE_0000 ^ (VTB + 32'(num) * 4));
        chk("R2", "sp after push", sp, SPI - 32);
        chk("R2", "beats on entry", 32'(lg_n), 32'(FW + 1));
        bad = 0;
        for (int k = 0; k < FW; k++)
            if (lg_we[k] !== 1'b1 || lg_addr[k] !== SPI - 32'(4 * (k + 1)) || lg_slot[k] !== 3'(k)) bad++;
        chk("R2", "push order/addresses", 32'(bad), 32'd0);
        chk("R3", "vector read address", lg_addr[FW], VTB + 32'(num) * 4);
    endtask

    // Return with nothing pending; check the full pop sequence.
    task automatic do_exit();
        int bad;
        tick();
        lg_n = 0;
        hret = 1'b1;
        tick();
        hret = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!act_valid) break;
        end
        chk("R4", "pop beats", 32'(lg_n), 32'(FW));
        bad = 0;
        for (int j = 0; j < FW; j++)
            if (lg_we[j] !== 1'b0 || lg_addr[j] !== SPI - 32 + 32'(4 * j) || lg_slot[j] !== 3'(FW - 1 - j)) bad++;
        chk("R4", "pop order/addresses", 32'(bad), 32'd0);
        chk("R4", "sp after pop", sp, SPI);
        chk("R4", "act_valid after pop", 32'(act_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "sp", sp, SPI);
        chk("R1", "act_valid", 32'(act_valid), 32'd0);
        chk("R1", "branch", 32'(branch), 32'd0);
        chk("R1", "act_upd", 32'(act_upd), 32'd0);
    endtask

    task automatic t_basic();
        do_entry(4'd5, 3'd4);
        do_exit();
    endtask

    task automatic t_hret_idle();
        tick();
        lg_n = 0;
        hret = 1'b1;
        tick();
        hret = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10", "beats after idle return", 32'(lg_n), 32'd0);
        chk("R10", "act_valid", 32'(act_valid), 32'd0);
        chk("R10", "sp", sp, SPI);
    endtask

    task automatic t_late();
        bit seen;
        lg_n = 0;
        pend_valid = 1'b1; pend_num = 4'd3; pend_prio = 3'd5;
        tick();
        pend_num = 4'd7; pend_prio = 3'd6;
        wait_log(2);
        @(negedge clk);
        chk("R6", "less urgent ignored", 32'(act_num), 32'd3);
        tick();
        pend_num = 4'd9; pend_prio = 3'd1;
        tick();
        @(negedge clk);
        chk("R9", "act_upd on late arrival", 32'(act_upd), 32'd1);
        chk("R6", "late act_num", 32'(act_num), 32'd9);
        chk("R6", "late act_prio", 32'(act_prio), 32'd1);
        wait_branch(seen);
        pend_valid = 1'b0;
        chk("R6", "frame still complete", 32'(lg_n), 32'(FW + 1));
        chk("R6", "redirected vector", lg_addr[FW], VTB + 32'd36);
        chk("R6", "handler", handler_addr, 32'hC0DE_0000 ^ (VTB + 32'd36));
        do_exit();
    endtask

    task automatic t_tail();
        bit seen;
        do_entry(4'd4, 3'd3);
        tick();
        lg_n = 0;
        pend_valid = 1'b1; pend_num = 4'd2; pend_prio = 3'd2;
        hret = 1'b1;
        tick();
        hret = 1'b0;
        pend_valid = 1'b0;
        @(negedge clk);
        chk("R9", "act_upd on tail chain", 32'(act_upd), 32'd1);
        wait_branch(seen);
        chk("R5", "only vector read", 32'(lg_n), 32'd1);
        chk("R5", "vector address", lg_addr[0], VTB + 32'd8);
        chk("R5", "sp unchanged", sp, SPI - 32);
        chk("R5", "act_num", 32'(act_num), 32'd2);
        do_exit();
    endtask

    task automatic t_popre();
        bit seen;
        do_entry(4'd6, 3'd4);
        tick();
        lg_n = 0;
        hret = 1'b1;
        tick();
        hret = 1'b0;
        wait_log(3);
        pend_valid = 1'b1; pend_num = 4'd11; pend_prio = 3'd3;
        wait_branch(seen);
        pend_valid = 1'b0;
        chk("R7", "branch after preempt", 32'(seen), 32'd1);
        chk("R7", "beats", 32'(lg_n), 32'd5);
        chk("R7", "vector address", lg_addr[4], VTB + 32'd44);
        chk("R7", "sp keeps frame", sp, SPI - 32);
        chk("R7", "act_num", 32'(act_num), 32'd11);
        do_exit();
    endtask

    task automatic t_stall();
        bit seen;
        int bad;
        rdy_en = 1'b0;
        lg_n = 0;
        pend_valid = 1'b1; pend_num = 4'd1; pend_prio = 3'd0;
        tick();
        pend_valid = 1'b0;
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (mem_req !== 1'b1 || mem_we !== 1'b1 || mem_addr !== SPI - 4 || mem_slot !== 3'd0 || sp !== SPI) bad++;
        end
        chk("R8", "held while not ready", 32'(bad), 32'd0);
        tick();
        rdy_en = 1'b1;
        wait_branch(seen);
        chk("R8", "completes after ready", 32'(lg_n), 32'(FW + 1));
        chk("R8", "handler", handler_addr, 32'hC0DE_0000 ^ (VTB + 32'd4));
        do_exit();
    endtask

    initial begin
        rst_n = 1'b0; pend_valid = 1'b0; pend_num = '0; pend_prio = '0;
        hret = 1'b0; rdy_en = 1'b1; lg_n = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_hret_idle();
        t_late();
        t_tail();
        t_popre();
        t_stall();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule